// File: doc/BRIEF.md
# Parallel Bus to Microwire Bridge

This block lets host software run a three-wire serial EEPROM of the Microwire kind (chip select, serial clock, serial data in, serial data out) through plain byte writes and reads on an 8-bit parallel data bus. Software sends one byte value to open chip select and another byte value to close it. While the device is selected, every other written byte is a control byte. One bit of that byte sets the serial data-in line and another bit sets the serial clock. Each edge of a serial frame is therefore produced by its own bus write.

The EEPROM's serial output is sampled into a capture register on every block clock while chip select is open. When the active-low output enable is low, software reads that captured bit back on one bus lane, and the other lanes read as 0. When output enable is high, the bus driver releases the bus. A pair of constant outputs supplies the EEPROM's power rails. The block does not sequence frames by itself. Software builds the full read frame: a start bit of 1, opcode bits 1 then 0, and a 6-bit address sent most significant bit first. The device then answers with a 0 dummy bit followed by 16 data bits.

Top module: `pbus_uwire_bridge`

## Requirements
- R1: A clock edge with `rst_n` low clears chip select, serial clock, data-in and the captured bit to 0.
- R2: While deselected, a write of the open byte 0x38 sets `ee_cs` after the next clock edge, with `ee_sk` and `ee_di` at 0.
- R3: While deselected, a written byte other than 0x38 is ignored: `ee_cs`, `ee_sk` and `ee_di` stay 0.
- R4: While selected, a written byte other than 0x38 and 0x05 loads `ee_di` from byte bit 0 and `ee_sk` from byte bit 1 at the next clock edge. Without a write, both lines hold their values.
- R5: While selected, a write of 0x38 keeps `ee_cs` at 1 and drives `ee_sk` and `ee_di` to 0.
- R6: A write of the close byte 0x05 clears `ee_cs`, `ee_sk`, `ee_di` and the captured bit at the next clock edge. While deselected, `ee_sk` and `ee_di` stay 0.
- R7: While `ee_cs` is 1, the captured bit takes the value of `eeprom_so` at every clock edge. While deselected, it is 0.
- R8: When `bus_oe_n` is low, `bus_drv` is 1 and `bus_q` carries the captured bit on bit 7, with bits 6..0 at 0. When `bus_oe_n` is high, `bus_drv` is 0 and `bus_q` is high-impedance.
- R9: `pwr_hi` is always 1 and `pwr_lo` is always 0.
- R10: A read frame driven by software (start bit 1, opcode 1 then 0, 6-bit address MSB first, one clock pulse per bit) delivers the address to the device. Reading after each further clock pulse returns the 0 dummy bit and then the 16 data bits, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the byte on `bus_din` |
| bus_din | input | 8 | Byte written by host software |
| bus_oe_n | input | 1 | Active-low output enable for the bus read |
| eeprom_so | input | 1 | Serial data output from the EEPROM |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_di | output | 1 | Serial data into the EEPROM |
| bus_q | output | 8 | Read-back byte; high-impedance when not enabled |
| bus_drv | output | 1 | High while the bus driver is enabled |
| pwr_hi | output | 1 | Constant 1 supply rail |
| pwr_lo | output | 1 | Constant 0 supply rail |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, open byte 0x38, close byte 0x05, data-in on lane 0, serial clock on lane 1 and read-back on lane 7. With these values the opcode collisions can be reached: 0x38 written while already selected, and 0x05 arriving with serial clock or data-in high. The same values let a bench-side EEPROM model take a complete 9-bit command and return a dummy bit followed by 16 data bits, so a whole read frame is carried out through byte writes.

// File: rtl/uw_bridge_pkg.sv
// Package: shared types for the parallel bus to Microwire bridge.
// Assumes: one decoded action is produced per block clock.
package uw_bridge_pkg;

    // Action decoded from the bus write strobe and the current select state.
    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_OPEN  = 3'd1,
        ACT_CLOSE = 3'd2,
        ACT_CTRL  = 3'd3,
        ACT_REARM = 3'd4
    } uw_act_e;

endpackage

// File: rtl/uw_cmd_decode.sv
// Module: uw_cmd_decode
// Classifies each bus write as open, close, control, re-arm or nothing,
// depending on whether chip select is currently asserted.
// Assumes: bus_din is stable whenever bus_wr is high.
module uw_cmd_decode
    import uw_bridge_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] OPEN_CMD  = 8'h38,
    parameter logic [DATA_W-1:0] CLOSE_CMD = 8'h05
) (
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              cs_q,
    output uw_act_e           act
);

    localparam logic [DATA_W-1:0] OPEN_C  = OPEN_CMD;
    localparam logic [DATA_W-1:0] CLOSE_C = CLOSE_CMD;

    // Map the write and select state onto a single action.
    always_comb begin
        act = ACT_NONE;
        if (bus_wr) begin
            if (!cs_q) begin
                if (bus_din == OPEN_C) act = ACT_OPEN;
            end else if (bus_din == CLOSE_C) begin
                act = ACT_CLOSE;
            end else if (bus_din == OPEN_C) begin
                act = ACT_REARM;
            end else begin
                act = ACT_CTRL;
            end
        end
    end

endmodule

// File: rtl/uw_serial_regs.sv
// Module: uw_serial_regs
// Holds the chip-select, serial-clock, data-in and captured data-out bits.
// Clock, data-in and capture can move only while chip select is set.
// Assumes: synchronous active-low reset.
module uw_serial_regs
    import uw_bridge_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DI_LANE = 0,
    parameter int SK_LANE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  uw_act_e           act,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              eeprom_so,
    output logic              cs_q,
    output logic              sk_q,
    output logic              di_q,
    output logic              cap_q
);

    // Update the select, clock and data-in registers from the decoded action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
            sk_q <= 1'b0;
            di_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_OPEN, ACT_REARM: begin
                    cs_q <= 1'b1;
                    sk_q <= 1'b0;
                    di_q <= 1'b0;
                end
                ACT_CLOSE: begin
                    cs_q <= 1'b0;
                    sk_q <= 1'b0;
                    di_q <= 1'b0;
                end
                ACT_CTRL: begin
                    sk_q <= bus_din[SK_LANE];
                    di_q <= bus_din[DI_LANE];
                end
                default: ;
            endcase
        end
    end

    // Sample the EEPROM serial output while selected; park it at 0 otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cap_q <= 1'b0;
        else if (cs_q && act != ACT_CLOSE)   cap_q <= eeprom_so;
        else                                 cap_q <= 1'b0;
    end

endmodule

// File: rtl/uw_bus_drive.sv
// Module: uw_bus_drive
// Puts the captured bit on one lane of the read bus while output enable
// is low, drives the other lanes to 0, and floats the bus otherwise.
// Assumes: the board shares the bus with other drivers.
module uw_bus_drive #(
    parameter int DATA_W  = 8,
    parameter int DO_LANE = 7
) (
    input  logic              bus_oe_n,
    input  logic              cap_q,
    output logic [DATA_W-1:0] bus_q,
    output logic              bus_drv
);

    assign bus_drv = ~bus_oe_n;

    // One tri-state driver per lane; only DO_LANE carries data.
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        if (g == DO_LANE) begin : g_data
            assign bus_q[g] = bus_drv ? cap_q : 1'bz;
        end else begin : g_zero
            assign bus_q[g] = bus_drv ? 1'b0 : 1'bz;
        end
    end

endmodule

// File: rtl/pbus_uwire_bridge.sv
// Module: pbus_uwire_bridge (top)
// Lets software run a Microwire EEPROM through byte writes and reads on a
// parallel bus, and supplies constant supply-rail outputs.
// Assumes: one bus write per strobe cycle; software handles frame timing.
module pbus_uwire_bridge
    import uw_bridge_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] OPEN_CMD  = 8'h38,
    parameter logic [DATA_W-1:0] CLOSE_CMD = 8'h05,
    parameter int                DI_LANE   = 0,
    parameter int                SK_LANE   = 1,
    parameter int                DO_LANE   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_oe_n,
    input  logic              eeprom_so,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    output logic [DATA_W-1:0] bus_q,
    output logic              bus_drv,
    output logic              pwr_hi,
    output logic              pwr_lo
);

    uw_act_e act;
    logic    cap_q;

    uw_cmd_decode #(
        .DATA_W(DATA_W), .OPEN_CMD(OPEN_CMD), .CLOSE_CMD(CLOSE_CMD)
    ) i_decode (
        .bus_wr(bus_wr), .bus_din(bus_din), .cs_q(ee_cs), .act(act)
    );

    uw_serial_regs #(
        .DATA_W(DATA_W), .DI_LANE(DI_LANE), .SK_LANE(SK_LANE)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .act(act), .bus_din(bus_din),
        .eeprom_so(eeprom_so), .cs_q(ee_cs), .sk_q(ee_sk), .di_q(ee_di),
        .cap_q(cap_q)
    );

    uw_bus_drive #(
        .DATA_W(DATA_W), .DO_LANE(DO_LANE)
    ) i_drive (
        .bus_oe_n(bus_oe_n), .cap_q(cap_q), .bus_q(bus_q), .bus_drv(bus_drv)
    );

    // Supply rails for the EEPROM, always enabled.
    assign pwr_hi = 1'b1;
    assign pwr_lo = 1'b0;

endmodule

// File: rtl/uw_bridge_checker.sv
// Module: uw_bridge_checker
// Temporal checks on the bridge's ports, attached by bind.
// Assumes: synchronous active-low reset; checks are off while it is low.
module uw_bridge_checker #(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] OPEN_CMD  = 8'h38,
    parameter logic [DATA_W-1:0] CLOSE_CMD = 8'h05,
    parameter int                DI_LANE   = 0,
    parameter int                SK_LANE   = 1,
    parameter int                DO_LANE   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_din,
    input logic              bus_oe_n,
    input logic              eeprom_so,
    input logic              ee_cs,
    input logic              ee_sk,
    input logic              ee_di,
    input logic [DATA_W-1:0] bus_q,
    input logic              bus_drv,
    input logic              pwr_hi,
    input logic              pwr_lo
);

    localparam logic [DATA_W-1:0] LOW_MASK = ~(DATA_W'(1) << DO_LANE);

    a_r2_open_sets_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!ee_cs && bus_wr && bus_din == OPEN_CMD) |=> (ee_cs && !ee_sk && !ee_di));

    a_r3_ignored_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ee_cs && bus_wr && bus_din != OPEN_CMD) |=> (!ee_cs && !ee_sk && !ee_di));

    a_r4_ctrl_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_cs && bus_wr && bus_din != OPEN_CMD && bus_din != CLOSE_CMD)
        |=> (ee_cs && ee_sk == $past(bus_din[SK_LANE]) && ee_di == $past(bus_din[DI_LANE])));

    a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_cs && bus_wr && bus_din == OPEN_CMD) |=> (ee_cs && !ee_sk && !ee_di));

    a_r6_close: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_cs && bus_wr && bus_din == CLOSE_CMD) |=> (!ee_cs && !ee_sk && !ee_di));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> (!ee_sk && !ee_di));

    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_cs && !(bus_wr && bus_din == CLOSE_CMD))
        |=> (bus_oe_n || bus_q[DO_LANE] == $past(eeprom_so)));

    a_r8_released: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_n |-> !bus_drv);

    a_r8_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> (bus_drv && (bus_q & LOW_MASK) == '0));

    a_r9_rails: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_hi && !pwr_lo);

endmodule

bind pbus_uwire_bridge uw_bridge_checker #(
    .DATA_W(DATA_W), .OPEN_CMD(OPEN_CMD), .CLOSE_CMD(CLOSE_CMD),
    .DI_LANE(DI_LANE), .SK_LANE(SK_LANE), .DO_LANE(DO_LANE)
) i_checker (.*);

// File: tb/test_pbus_uwire_bridge.sv
// Bench for pbus_uwire_bridge: a vector table, then directed tests for
// reset, bus release, rails and a complete read frame against an EEPROM model.
module test_pbus_uwire_bridge;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic       bus_oe_n = 1'b1;
    logic       so_force = 1'b0;
    logic       use_model = 1'b0;
    logic       eeprom_so;
    logic       ee_cs, ee_sk, ee_di, bus_drv, pwr_hi, pwr_lo;
    logic [7:0] bus_q;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    // EEPROM model: counts rising serial clocks, takes 9 header bits, then returns data.
    logic       sk_prev = 1'b0;
    int         sk_cnt = 0;
    logic [8:0] hdr = '0;
    logic       model_so;
    logic [15:0] model_word;

    function automatic logic [15:0] word_of(input logic [5:0] a);
        return {~a, 2'b10, a, 2'b01};
    endfunction

    always @(posedge clk) begin
        sk_prev <= ee_sk;
        if (!ee_cs) begin
            sk_cnt <= 0;
        end else if (ee_sk && !sk_prev) begin
            if (sk_cnt < 9) hdr <= {hdr[7:0], ee_di};
            sk_cnt <= sk_cnt + 1;
        end
    end

    assign model_word = word_of(hdr[5:0]);
    assign model_so   = (sk_cnt >= 10 && sk_cnt <= 25) ? model_word[25 - sk_cnt] : 1'b0;
    assign eeprom_so  = use_model ? model_so : so_force;

    pbus_uwire_bridge i_pbus_uwire_bridge (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_din(bus_din),
        .bus_oe_n(bus_oe_n), .eeprom_so(eeprom_so), .ee_cs(ee_cs),
        .ee_sk(ee_sk), .ee_di(ee_di), .bus_q(bus_q), .bus_drv(bus_drv),
        .pwr_hi(pwr_hi), .pwr_lo(pwr_lo)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Vector: write, byte, oe_n, so, then expected cs, sk, di, bus bit 7.
    typedef struct packed {
        logic       wr;
        logic [7:0] din;
        logic       oe_n;
        logic       so;
        logic       cs;
        logic       sk;
        logic       di;
        logic       b7;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 ignored while idle
        '{1'b1, 8'h38, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 open
        '{1'b1, 8'h03, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 R7 control, capture 1
        '{1'b1, 8'h02, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 R7 capture 0
        '{1'b0, 8'h01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R4 hold without write
        '{1'b1, 8'h38, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 rearm
        '{1'b1, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 data-in only
        '{1'b1, 8'h03, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 both high
        '{1'b1, 8'h05, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 close clears
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 no capture idle
        '{1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 ignored 0xFF
        '{1'b1, 8'h07, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}  // R3 ignored 0x07
    };

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk);
        bus_wr  = 1'b1;
        bus_din = b;
        @(negedge clk);
        bus_wr  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_bit(output logic v);
        bus_oe_n = 1'b0;
        #1;
        v = bus_q[7];
        bus_oe_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic       b;
        logic [5:0] addr;
        logic [15:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!ee_cs && !ee_sk && !ee_di, "R1 reset outputs", {ee_cs, ee_sk, ee_di}, 0);
        bus_oe_n = 1'b0;
        #1;
        check(bus_q == 8'h00, "R1 captured bit after reset", bus_q, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            bus_wr   = VECS[i].wr;
            bus_din  = VECS[i].din;
            bus_oe_n = VECS[i].oe_n;
            so_force = VECS[i].so;
            @(negedge clk);
            check({ee_cs, ee_sk, ee_di} == {VECS[i].cs, VECS[i].sk, VECS[i].di},
                  $sformatf("R2-6 vector %0d cs/sk/di", i), {ee_cs, ee_sk, ee_di},
                  {VECS[i].cs, VECS[i].sk, VECS[i].di});
            check(bus_q == {VECS[i].b7, 7'b0} && bus_drv,
                  $sformatf("R7 R8 vector %0d bus", i), bus_q, {VECS[i].b7, 7'b0});
        end
        bus_wr = 1'b0;

        // R8 bus released with oe_n high
        bus_oe_n = 1'b1;
        #1;
        check(!bus_drv, "R8 released when oe_n high", bus_drv, 0);
        // R9 rails
        check(pwr_hi && !pwr_lo, "R9 rails", {pwr_hi, pwr_lo}, 2'b10);

        // R1 reset in the middle of an operation
        wr_byte(8'h38);
        so_force = 1'b1;
        wr_byte(8'h03);
        check(ee_cs && ee_sk && ee_di, "R4 setup before reset", {ee_cs, ee_sk, ee_di}, 3'b111);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_oe_n = 1'b0;
        #1;
        check(!ee_cs && !ee_sk && !ee_di, "R1 mid-operation reset", {ee_cs, ee_sk, ee_di}, 0);
        check(bus_q == 8'h00, "R1 capture cleared", bus_q, 0);
        bus_oe_n = 1'b1;
        so_force = 1'b0;

        // R10 complete read frames through the model
        use_model = 1'b1;
        foreach (addr_list[k]) begin
            addr = addr_list[k];
            wr_byte(8'h38);
            for (int j = 8; j >= 0; j--) begin
                b = (j == 8) ? 1'b1 : (j == 7) ? 1'b1 : (j == 6) ? 1'b0 : addr[j];
                wr_byte({6'b0, 1'b0, b});
                wr_byte({6'b0, 1'b1, b});
                wr_byte({6'b0, 1'b0, b});
            end
            check(hdr == {3'b110, addr}, "R10 header received", hdr, {3'b110, addr});
            read_bit(b);
            check(b == 1'b0, "R10 dummy bit", b, 0);
            for (int j = 15; j >= 0; j--) begin
                wr_byte(8'h02);
                wr_byte(8'h00);
                read_bit(b);
                got[j] = b;
            end
            check(got == word_of(addr), "R10 data word", got, word_of(addr));
            wr_byte(8'h05);
            check(!ee_cs, "R6 close after frame", ee_cs, 0);
        end

        finish_run();
    end

    logic [5:0] addr_list [3] = '{6'h2A, 6'h15, 6'h3F};

endmodule